// File: doc/BRIEF.md
# Shared interrupt line aggregator

This block merges level-sensitive interrupt requests from a set of devices onto a smaller group of shared interrupt lines. Every device offers four request pins. Each pin is steered to one shared line by a fixed rotation: the pin number is offset by the device slot number, and the result wraps modulo the line count. This rotation spreads the pin 0 requests of successive devices across different lines.

Each line is not built as a wide OR gate. The block keeps a running count of how many mapped sources are currently asserted. It also remembers the last reported level of every source pin. An update therefore moves a counter only when it is a genuine transition. A repeated report of the same level leaves everything as it was.

Several sources may report in the same clock cycle. The block folds their changes into the affected counters one after another, in ascending source index, so that no step is lost. A line is driven high while its counter is nonzero.

Top module: `irq_share_agg`

## Requirements
- R1: Each device owns four request pins numbered 0 to 3. The flat source index is `dev*4 + pin`, and bit `s` of `upd_valid` and of `upd_level` belongs to source `s`.
- R2: The block stores the last level of every source. An update whose level equals the stored level changes no stored level and no line. This holds whether the repeat is high-high or low-low.
- R3: An update whose level differs from the stored level adds +1 (rise) or -1 (fall) to the counter of the line that source maps to.
- R4: A line output `irq_line[l]` is high exactly when its counter is nonzero. It follows an update one clock edge later, so each line acts as the OR of the stored levels of its mapped sources.
- R5: Source (dev, pin) drives line `(pin + dev) mod NUM_LINES`.
- R6: Updates from many sources in one cycle are all applied, in ascending source index. None is lost, including a rise and a fall that land on the same line.
- R7: Reset (`rst` high, synchronous) clears every stored level and every counter, so all lines read low.
- R8: Counters are wide enough for every source to be asserted together. With all sources high every line stays high, and after all of them fall every line returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | NUM_DEV*4 | Per-source update strobe |
| upd_level | input | NUM_DEV*4 | Level reported with the update |
| irq_line | output | NUM_LINES | Shared interrupt line outputs |

## Verification
The bench builds the block with four devices and four lines. Each line then collects exactly four sources, one from each device, and the rotation is easy to see: pin 0 of device d lands on line d. This size also lets a single cycle raise every source at once, which drives every counter to its largest value. It also allows a rise on one source and a fall on another that share a line in the same cycle.

Beyond that, seeded random bursts of updates are compared each cycle against a model that ORs the remembered levels per line.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int PINS_PER_DEV = 4;

  // Rotation of pin by device slot onto the shared lines.
  function automatic int route_line(input int src, input int nlines);
    int dev;
    int pin;
    dev = src / PINS_PER_DEV;
    pin = src % PINS_PER_DEV;
    return (pin + dev) % nlines;
  endfunction

  // Width of a counter able to hold n.
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irq_src_tracker.sv
module irq_src_tracker #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] upd_valid,
  input  logic [NSRC-1:0] upd_level,
  output logic [NSRC-1:0] src_level_q,
  output logic [NSRC-1:0] src_rise,
  output logic [NSRC-1:0] src_fall
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic changed;
    assign changed     = upd_valid[s] && (upd_level[s] != src_level_q[s]);
    assign src_rise[s] = changed && upd_level[s];
    assign src_fall[s] = changed && !upd_level[s];

    always_ff @(posedge clk) begin
      if (rst) src_level_q[s] <= 1'b0;
      else if (changed) src_level_q[s] <= upd_level[s];
    end

    AST_SAME_LEVEL_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (upd_valid[s] && upd_level[s] == src_level_q[s]) |=> $stable(src_level_q[s])); // R2
  end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import irq_agg_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int NLINES   = 4,
  parameter int LINE_IDX = 0,
  parameter int CW       = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_rise,
  input  logic [NSRC-1:0] src_fall,
  output logic [CW-1:0]   count_q,
  output logic            line_active
);

  logic [CW-1:0] count_next;

  // Fold every source step into the running count in ascending order.
  always_comb begin
    count_next = count_q;
    for (int s = 0; s < NSRC; s++) begin
      if (route_line(s, NLINES) == LINE_IDX) begin
        count_next = count_next + CW'(src_rise[s]) - CW'(src_fall[s]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_next;
  end

  assign line_active = (count_q != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(NSRC)); // R8

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] upd_valid,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] upd_level,
  output logic [NUM_LINES-1:0]        irq_line
);

  localparam int NSRC = NUM_DEV * PINS_PER_DEV;
  localparam int CW   = count_bits(NSRC);

  logic [NSRC-1:0] src_level_q;
  logic [NSRC-1:0] src_rise;
  logic [NSRC-1:0] src_fall;

  irq_src_tracker #(.NSRC(NSRC)) u_track (
    .clk        (clk),
    .rst        (rst),
    .upd_valid  (upd_valid),
    .upd_level  (upd_level),
    .src_level_q(src_level_q),
    .src_rise   (src_rise),
    .src_fall   (src_fall)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CW-1:0] line_count;
    logic [CW-1:0] held_ones;

    irq_line_counter #(
      .NSRC(NSRC), .NLINES(NUM_LINES), .LINE_IDX(l), .CW(CW)
    ) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .src_rise   (src_rise),
      .src_fall   (src_fall),
      .count_q    (line_count),
      .line_active(irq_line[l])
    );

    // Population of stored high levels routed to this line.
    always_comb begin
      held_ones = '0;
      for (int s = 0; s < NSRC; s++) begin
        if (route_line(s, NUM_LINES) == l) held_ones = held_ones + CW'(src_level_q[s]);
      end
    end

    AST_COUNT_MATCHES_LEVELS: assert property (@(posedge clk) disable iff (rst)
      line_count == held_ones); // R3
    AST_LINE_IS_OR: assert property (@(posedge clk) disable iff (rst)
      irq_line[l] == (held_ones != '0)); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (line_count == '0)); // R7
  end

endmodule

// File: tb/irq_share_agg_tb.sv
module irq_share_agg_tb;

  localparam int NDEV = 4;
  localparam int NL   = 4;
  localparam int NS   = NDEV * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] upd_valid = '0;
  logic [NS-1:0] upd_level = '0;
  logic [NL-1:0] irq_line;

  logic [NS-1:0] mdl = '0;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_share_agg #(.NUM_DEV(NDEV), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_level(upd_level),
    .irq_line(irq_line)
  );

  function automatic int tb_line_of(input int dev, input int pin);
    return (dev + pin) % NL;
  endfunction

  function automatic logic [NL-1:0] expect_lines(input logic [NS-1:0] lv);
    logic [NL-1:0] r;
    r = '0;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        if (lv[d*4+p]) r[tb_line_of(d, p)] = 1'b1;
    return r;
  endfunction

  task automatic apply(input logic [NS-1:0] v, input logic [NS-1:0] lv);
    @(negedge clk);
    upd_valid = v;
    upd_level = lv;
    for (int s = 0; s < NS; s++) if (v[s]) mdl[s] = lv[s];
    @(posedge clk);
    #1;
    upd_valid = '0;
  endtask

  task automatic check(input string req, input logic [NL-1:0] exp);
    checks++;
    if (irq_line !== exp) begin
      fails++;
      $display("FAIL %s: irq_line=%b expected=%b", req, irq_line, exp);
    end
  endtask

  function automatic logic [NS-1:0] one(input int d, input int p);
    logic [NS-1:0] r;
    r = '0;
    r[d*4+p] = 1'b1;
    return r;
  endfunction

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R7 after reset release", '0);

    // R5 / R1: pin 0 of device d lands on line d
    for (int d = 0; d < NDEV; d++) begin
      apply(one(d, 0), one(d, 0));
      check("R5 rotation raise", expect_lines(mdl));
      apply(one(d, 0), '0);
      check("R5 rotation drop", '0);
    end
    apply(one(1, 3), one(1, 3));
    check("R5 wrap dev1 pin3 -> line0", 4'b0001);
    apply(one(1, 3), '0);

    // R2: repeated high counts once
    apply(one(0, 0), one(0, 0));
    apply(one(0, 0), one(0, 0));
    check("R2 repeat high", 4'b0001);
    apply(one(0, 0), '0);
    check("R2 single drop clears after repeat", 4'b0000);
    // R2: low on an already-low source must not underflow
    apply(one(2, 2), '0);
    check("R2 repeat low no effect", 4'b0000);
    apply(one(3, 1), one(3, 1));
    check("R2 line0 after redundant low", 4'b0001);
    apply(one(3, 1), '0);
    check("R2 line0 clears", 4'b0000);

    // R3 / R6: two sources on line 1 raised in one cycle
    apply(one(0, 1) | one(1, 0), one(0, 1) | one(1, 0));
    check("R6 simultaneous raise", 4'b0010);
    apply(one(0, 1), '0);
    check("R3 one of two dropped keeps line", 4'b0010);
    // rise and fall on the same line in one cycle
    apply(one(1, 0) | one(2, 3), one(2, 3));
    check("R6 rise+fall same cycle", 4'b0010);
    apply(one(2, 3), '0);
    check("R3 last drop clears", 4'b0000);

    // R8: all sources high, then all low
    apply('1, '1);
    check("R8 all high", 4'b1111);
    apply('1, '1);
    check("R8 all high repeated", 4'b1111);
    apply('1, '0);
    check("R8 all low", 4'b0000);

    // R4: random bursts against the OR model
    for (int i = 0; i < 400; i++) begin
      logic [NS-1:0] v;
      logic [NS-1:0] lv;
      v  = NS'($urandom) & NS'($urandom);
      lv = NS'($urandom);
      apply(v, lv);
      check("R4 random OR of levels", expect_lines(mdl));
    end

    // R7: reset mid-run clears all
    apply('1, '1);
    @(negedge clk);
    rst = 1'b1;
    mdl = '0;
    @(posedge clk);
    #1;
    check("R7 reset mid-run", '0);
    @(negedge clk);
    rst = 1'b0;
    apply(one(2, 0), one(2, 0));
    check("R7 state cleared, fresh raise", 4'b0100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule